// File: doc/BRIEF.md
# Test Access Port with Static Test-Mode Control

This block is a serial test access port clocked by its own test clock. A five-wire serial link (clock, mode select, data in, data out, and an active-low asynchronous reset) drives a sixteen-state controller. Through that controller a tester loads an instruction and then moves data through whichever register the instruction picks. The same few pins can then set any number of chip-level test-mode levels that stay constant for a whole test run, with no dedicated package pin for each one.

Two instructions do the real work. The first selects a four-bit control register. Its held bits drive the core test-mode levels: internal mode, external mode, internal logic-test enable and external logic-test enable. These levels keep their value while the controller idles, until a later scan changes them. The second selects an embedded instrument network. For that instruction the port raises a network-select line and passes on capture, shift and update strobes, and the network's serial return is routed to the data output. Every other code, including the mandatory external-test and sample/preload codes, routes the scan through a one-bit bypass stage. No boundary cells are present for those two codes to act on.

Top module: `test_port_ctrl`

## Requirements
- R1: Driving `trst_n` low returns the controller to Test-Logic-Reset at once, without waiting for a clock edge. Holding `tms` high for five consecutive rising `tck` edges reaches Test-Logic-Reset from any state.
- R2: In Capture-IR the three-bit instruction shift stage loads 3'b001. The first bit shifted out on `tdo` is therefore 1, the second is 0 and the third is 0.
- R3: In Shift-IR and Shift-DR, each rising `tck` edge moves one `tdi` bit into the most significant end of the selected shift stage. The least significant bit of that stage is presented on `tdo`, which changes only on falling `tck` edges.
- R4: The instruction hold register changes only on the falling edge in Update-IR. The control hold register changes only on the falling edge in Update-DR while the control instruction is active. Shifting alone never disturbs the static outputs.
- R5: While the controller is in Capture-IR through Update-IR, `tdo` carries the instruction stage. In every other shift it carries the data register that the held instruction picks.
- R6: From Pause-IR or Pause-DR, any number of cycles with `tms` low leaves the shift contents untouched. Exit2 with `tms` low resumes shifting, and Exit2 with `tms` high goes to Update.
- R7: The control register is 4 bits wide: bit 0 drives `ctl_int_mode`, bit 1 `ctl_ext_mode`, bit 2 `ctl_int_ltest` and bit 3 `ctl_ext_ltest`. The first bit shifted lands in bit 0. Capture-DR loads the held value into the shift stage, and the held value persists through Run-Test/Idle.
- R8: Instruction decoding uses the 3-bit held code. 3'b001 selects the control register and 3'b010 the instrument network. 3'b111 (bypass), 3'b000 (external test), 3'b011 (sample/preload) and every other code select the 1-bit bypass stage, which captures 0.
- R9: While 3'b010 is held, `net_select` is 1 and `net_capture_en`, `net_shift_en` and `net_update_en` are high exactly in Capture-DR, Shift-DR and Update-DR. Data shifted in Shift-DR reaches `tdo` from `net_so`. With any other code all four outputs are 0.
- R10: Test-Logic-Reset sets the instruction hold register to 3'b111 and clears the control hold register. `tdo_en` is 1 only in Shift-IR and Shift-DR, and `tdo` is 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select steering the controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling edges |
| tdo_en | output | 1 | High while `tdo` carries scan data |
| ctl_int_mode | output | 1 | Held control bit 0 |
| ctl_ext_mode | output | 1 | Held control bit 1 |
| ctl_int_ltest | output | 1 | Held control bit 2 |
| ctl_ext_ltest | output | 1 | Held control bit 3 |
| net_select | output | 1 | Instrument network chosen by the held instruction |
| net_capture_en | output | 1 | Network capture strobe |
| net_shift_en | output | 1 | Network shift strobe |
| net_update_en | output | 1 | Network update strobe |
| net_so | input | 1 | Serial return from the instrument network |

## Verification
The hardest situation to reach from the pins is a data scan that is parked in Pause-DR part-way through, with `tdi` toggling, and then resumed through Exit2. Only that sequence shows that neither the shift stage nor the held outputs moved while the scan was parked. The bench builds it from explicit `tms` sequences: two bits are shifted, the scan pauses for several cycles with `tdi` high, and the last two bits follow before the update. A second awkward case is the five-high `tms` escape started from inside Shift-DR. That path passes through Update-DR and briefly loads a partial word before the reset state clears it. The bench walks that path and then proves through a bypass scan that the instruction fell back to bypass.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic [3:0] {
    ST_TLR,
    ST_RTI,
    ST_SEL_DR,
    ST_CAP_DR,
    ST_SH_DR,
    ST_EX1_DR,
    ST_PAU_DR,
    ST_EX2_DR,
    ST_UPD_DR,
    ST_SEL_IR,
    ST_CAP_IR,
    ST_SH_IR,
    ST_EX1_IR,
    ST_PAU_IR,
    ST_EX2_IR,
    ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    PATH_BYPASS,
    PATH_CTRL,
    PATH_NET
  } dr_path_e;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state_q
);

  localparam int RESET_RUN = 5;
  localparam int RUN_W     = $clog2(RESET_RUN + 1);

  tap_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= ST_TLR;
    else        state_q <= state_d;
  end

  // Checker-only run counter of consecutive high tms edges
  logic [RUN_W-1:0] tms_run;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                                    tms_run <= '0;
    else if (!tms)                                 tms_run <= '0;
    else if (tms_run != RESET_RUN[RUN_W-1:0])      tms_run <= tms_run + 1'b1;
  end

  // R1: five high tms edges always land in Test-Logic-Reset
  p_tms_escape_r1: assert property (@(posedge tck) disable iff (!rst_n)
    (tms_run == RESET_RUN[RUN_W-1:0]) |-> (state_q == ST_TLR));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter int              IR_W      = 3,
  parameter logic [IR_W-1:0] CAP_PAT   = 'b01,
  parameter logic [IR_W-1:0] OP_CTRL   = 'b001,
  parameter logic [IR_W-1:0] OP_NET    = 'b010,
  parameter logic [IR_W-1:0] OP_EXTEST = 'b000,
  parameter logic [IR_W-1:0] OP_SAMPLE = 'b011
) (
  input  logic       tck,
  input  logic       rst_n,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_so,
  output dr_path_e   path
);

  localparam logic [IR_W-1:0] OP_BYPASS = '1;

  logic [IR_W-1:0] sr_q, sr_d;
  logic [IR_W-1:0] hold_q, hold_d;

  always_comb begin
    sr_d = sr_q;
    if (state == ST_CAP_IR)     sr_d = CAP_PAT;
    else if (state == ST_SH_IR) sr_d = {tdi, sr_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  always_comb begin
    hold_d = hold_q;
    if (state == ST_TLR)         hold_d = OP_BYPASS;
    else if (state == ST_UPD_IR) hold_d = sr_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) hold_q <= OP_BYPASS;
    else        hold_q <= hold_d;
  end

  // Decoder: external test and sample/preload have no boundary cells to use
  always_comb begin
    if (hold_q == OP_CTRL)        path = PATH_CTRL;
    else if (hold_q == OP_NET)    path = PATH_NET;
    else if (hold_q == OP_EXTEST) path = PATH_BYPASS;
    else if (hold_q == OP_SAMPLE) path = PATH_BYPASS;
    else                          path = PATH_BYPASS;
  end

  assign ir_so = sr_q[0];

  // R2: capture leaves 1 in bit 0 and 0 in bit 1
  p_capture_ir_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (sr_q[1:0] == 2'b01));

  // R4: hold moves only in Update-IR or reset state
  p_ir_hold_quiet_r4: assert property (@(negedge tck) disable iff (!rst_n)
    (state != ST_UPD_IR && state != ST_TLR) |=> $stable(hold_q));

  // R10: reset state holds the bypass code
  p_tlr_bypass_r10: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_TLR) |-> (hold_q == OP_BYPASS));

  // R6: pause keeps the instruction stage
  p_ir_pause_keep_r6: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_PAU_IR) |=> $stable(sr_q));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int CTL_W = 4
) (
  input  logic             tck,
  input  logic             rst_n,
  input  tap_state_e       state,
  input  dr_path_e         path,
  input  logic             tdi,
  input  logic             net_so,
  output logic [CTL_W-1:0] ctl_q,
  output logic             dr_so
);

  logic             byp_q, byp_d;
  logic [CTL_W-1:0] csr_q, csr_d;
  logic [CTL_W-1:0] chold_d;

  always_comb begin
    byp_d = byp_q;
    csr_d = csr_q;
    if (state == ST_CAP_DR) begin
      if (path == PATH_BYPASS) byp_d = 1'b0;
      if (path == PATH_CTRL)   csr_d = ctl_q;
    end else if (state == ST_SH_DR) begin
      if (path == PATH_BYPASS) byp_d = tdi;
      if (path == PATH_CTRL)   csr_d = {tdi, csr_q[CTL_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
      csr_q <= '0;
    end else begin
      byp_q <= byp_d;
      csr_q <= csr_d;
    end
  end

  always_comb begin
    chold_d = ctl_q;
    if (state == ST_TLR)                             chold_d = '0;
    else if (state == ST_UPD_DR && path == PATH_CTRL) chold_d = csr_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= chold_d;
  end

  always_comb begin
    case (path)
      PATH_CTRL: dr_so = csr_q[0];
      PATH_NET:  dr_so = net_so;
      default:   dr_so = byp_q;
    endcase
  end

  // R6: pause keeps the control shift stage
  p_dr_pause_keep_r6: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_PAU_DR) |=> $stable(csr_q));

  // R7 / R4: control hold moves only in Update-DR or reset state
  p_ctl_hold_quiet_r7: assert property (@(negedge tck) disable iff (!rst_n)
    (state != ST_UPD_DR && state != ST_TLR) |=> $stable(ctl_q));

  // R8: bypass stage captures zero
  p_bypass_capture_r8: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && path == PATH_BYPASS) |=> (byp_q == 1'b0));

endmodule

// File: rtl/test_port_ctrl.sv
module test_port_ctrl
  import tap_pkg::*;
#(
  parameter int            IR_W      = 3,
  parameter int            CTL_W     = 4,
  parameter logic [IR_W-1:0] CAP_PAT   = 'b01,
  parameter logic [IR_W-1:0] OP_CTRL   = 'b001,
  parameter logic [IR_W-1:0] OP_NET    = 'b010,
  parameter logic [IR_W-1:0] OP_EXTEST = 'b000,
  parameter logic [IR_W-1:0] OP_SAMPLE = 'b011
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_en,
  output logic ctl_int_mode,
  output logic ctl_ext_mode,
  output logic ctl_int_ltest,
  output logic ctl_ext_ltest,
  output logic net_select,
  output logic net_capture_en,
  output logic net_shift_en,
  output logic net_update_en,
  input  logic net_so
);

  localparam int SYNC_W = 2;

  // Asynchronous assertion, synchronous release of the test reset
  logic [SYNC_W-1:0] rst_sync_q;
  logic              rst_n;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_W-2:0], 1'b1};
  end
  assign rst_n = rst_sync_q[SYNC_W-1];

  tap_state_e       state;
  dr_path_e         path;
  logic             ir_so, dr_so;
  logic [CTL_W-1:0] ctl_q;

  tap_fsm u_fsm (
    .tck     (tck),
    .rst_n   (rst_n),
    .tms     (tms),
    .state_q (state)
  );

  tap_ir #(
    .IR_W      (IR_W),
    .CAP_PAT   (CAP_PAT),
    .OP_CTRL   (OP_CTRL),
    .OP_NET    (OP_NET),
    .OP_EXTEST (OP_EXTEST),
    .OP_SAMPLE (OP_SAMPLE)
  ) u_ir (
    .tck   (tck),
    .rst_n (rst_n),
    .state (state),
    .tdi   (tdi),
    .ir_so (ir_so),
    .path  (path)
  );

  tap_dr #(
    .CTL_W (CTL_W)
  ) u_dr (
    .tck    (tck),
    .rst_n  (rst_n),
    .state  (state),
    .path   (path),
    .tdi    (tdi),
    .net_so (net_so),
    .ctl_q  (ctl_q),
    .dr_so  (dr_so)
  );

  // Output selection: instruction branch versus data register mux
  logic ir_branch, shifting, ser_bit;
  logic tdo_d, tdo_en_d;

  always_comb begin
    ir_branch = (state == ST_CAP_IR) || (state == ST_SH_IR)  ||
                (state == ST_EX1_IR) || (state == ST_PAU_IR) ||
                (state == ST_EX2_IR) || (state == ST_UPD_IR);
    shifting  = (state == ST_SH_IR) || (state == ST_SH_DR);
    ser_bit   = ir_branch ? ir_so : dr_so;
    tdo_d     = shifting ? ser_bit : 1'b0;
    tdo_en_d  = shifting;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_en <= tdo_en_d;
    end
  end

  assign ctl_int_mode  = ctl_q[0];
  assign ctl_ext_mode  = ctl_q[1];
  assign ctl_int_ltest = ctl_q[2];
  assign ctl_ext_ltest = ctl_q[3];

  assign net_select     = (path == PATH_NET);
  assign net_capture_en = net_select && (state == ST_CAP_DR);
  assign net_shift_en   = net_select && (state == ST_SH_DR);
  assign net_update_en  = net_select && (state == ST_UPD_DR);

  // R10: output enable only follows a shift state
  p_tdo_en_shift_r10: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en |-> (state == ST_SH_IR || state == ST_SH_DR));

  // R9: an update strobe is never followed by a shift strobe
  p_net_after_update_r9: assert property (@(posedge tck) disable iff (!rst_n)
    net_update_en |=> !net_shift_en);

  // R9: at most one network strobe at a time
  p_net_strobe_single_r9: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({net_capture_en, net_shift_en, net_update_en}));

endmodule

// File: tb/test_port_ctrl_tb_top.sv
module test_port_ctrl_tb_top;

  localparam int TCK_PERIOD = 20;

  logic tck = 1'b0;
  logic trst_n, tms, tdi, net_so;
  logic tdo, tdo_en, c_im, c_em, c_il, c_el;
  logic n_sel, n_cap, n_sh, n_upd;

  always #(TCK_PERIOD/2) tck = ~tck;

  test_port_ctrl dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_en(tdo_en),
    .ctl_int_mode(c_im), .ctl_ext_mode(c_em),
    .ctl_int_ltest(c_il), .ctl_ext_ltest(c_el),
    .net_select(n_sel), .net_capture_en(n_cap),
    .net_shift_en(n_sh), .net_update_en(n_upd),
    .net_so(net_so)
  );

  int n_chk = 0;
  int n_err = 0;

  // Behavioural reference: state numbers are the bench's own
  localparam int M_RESET = 0, M_IDLE = 1,
                 M_DSEL = 2, M_DCAP = 3, M_DSH = 4, M_DX1 = 5, M_DPAU = 6, M_DX2 = 7, M_DUPD = 8,
                 M_ISEL = 9, M_ICAP = 10, M_ISH = 11, M_IX1 = 12, M_IPAU = 13, M_IX2 = 14, M_IUPD = 15;

  int         m_st;
  logic [2:0] m_irs, m_irh;
  logic [3:0] m_cs, m_ch;
  logic       m_byp, m_tdo, m_tdoen;

  function automatic int m_next(int s, logic t);
    case (s)
      M_RESET: return t ? M_RESET : M_IDLE;
      M_IDLE:  return t ? M_DSEL : M_IDLE;
      M_DSEL:  return t ? M_ISEL : M_DCAP;
      M_DCAP, M_DSH: return t ? M_DX1 : M_DSH;
      M_DX1:   return t ? M_DUPD : M_DPAU;
      M_DPAU:  return t ? M_DX2 : M_DPAU;
      M_DX2:   return t ? M_DUPD : M_DSH;
      M_DUPD, M_IUPD: return t ? M_DSEL : M_IDLE;
      M_ISEL:  return t ? M_RESET : M_ICAP;
      M_ICAP, M_ISH: return t ? M_IX1 : M_ISH;
      M_IX1:   return t ? M_IUPD : M_IPAU;
      M_IPAU:  return t ? M_IX2 : M_IPAU;
      M_IX2:   return t ? M_IUPD : M_ISH;
      default: return M_RESET;
    endcase
  endfunction

  // 0 bypass, 1 control, 2 network (R8 codes)
  function automatic int m_path();
    if (m_irh == 3'b001) return 1;
    if (m_irh == 3'b010) return 2;
    return 0;
  endfunction

  task automatic model_reset();
    m_st = M_RESET; m_irs = '0; m_irh = 3'b111; m_cs = '0; m_ch = '0;
    m_byp = 1'b0; m_tdo = 1'b0; m_tdoen = 1'b0;
  endtask

  task automatic model_rise(input logic t, input logic d);
    if (m_st == M_ICAP) m_irs = 3'b001;
    else if (m_st == M_ISH) m_irs = {d, m_irs[2:1]};
    else if (m_st == M_DCAP) begin
      if (m_path() == 0) m_byp = 1'b0;
      if (m_path() == 1) m_cs = m_ch;
    end else if (m_st == M_DSH) begin
      if (m_path() == 0) m_byp = d;
      if (m_path() == 1) m_cs = {d, m_cs[3:1]};
    end
    m_st = m_next(m_st, t);
  endtask

  task automatic model_fall(input logic ns);
    if (m_st == M_ISH) begin
      m_tdo = m_irs[0]; m_tdoen = 1'b1;
    end else if (m_st == M_DSH) begin
      m_tdoen = 1'b1;
      case (m_path())
        1: m_tdo = m_cs[0];
        2: m_tdo = ns;
        default: m_tdo = m_byp;
      endcase
    end else begin
      m_tdo = 1'b0; m_tdoen = 1'b0;
    end
    if (m_st == M_IUPD) m_irh = m_irs;
    else if (m_st == M_DUPD && m_path() == 1) m_ch = m_cs;
    else if (m_st == M_RESET) begin m_irh = 3'b111; m_ch = '0; end
  endtask

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [3:0] ctl;
    ctl = {c_el, c_il, c_em, c_im};
    check(tdo === m_tdo, "R3", "tdo", int'(tdo), int'(m_tdo));
    check(tdo_en === m_tdoen, "R10", "tdo_en", int'(tdo_en), int'(m_tdoen));
    check(ctl === m_ch, "R7", "control outputs", int'(ctl), int'(m_ch));
    check(n_sel === (m_path() == 2), "R8", "net_select", int'(n_sel), int'(m_path() == 2));
    check({n_cap, n_sh, n_upd} === {(m_path() == 2) && m_st == M_DCAP,
                                    (m_path() == 2) && m_st == M_DSH,
                                    (m_path() == 2) && m_st == M_DUPD},
          "R9", "network strobes", int'({n_cap, n_sh, n_upd}),
          int'({(m_path() == 2) && m_st == M_DCAP, (m_path() == 2) && m_st == M_DSH,
                (m_path() == 2) && m_st == M_DUPD}));
  endtask

  task automatic tick(input logic t, input logic d);
    tms = t; tdi = d; net_so = ~d;
    @(posedge tck);
    model_rise(t, d);
    @(negedge tck);
    model_fall(~d);
    #1;
    compare_all();
  endtask

  task automatic ir_scan(input logic [2:0] code, output logic [2:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      tick(i == 2, code[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic dr_scan4(input logic [3:0] data, output logic [3:0] cap);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      cap[i] = tdo;
      tick(i == 3, data[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic do_reset();
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; net_so = 1'b0;
    #1;
    model_reset();
    compare_all();
    check({c_el, c_il, c_em, c_im} === 4'b0000, "R1", "controls cleared by trst_n",
          int'({c_el, c_il, c_em, c_im}), 0);
    check(tdo_en === 1'b0, "R1", "tdo_en in reset", int'(tdo_en), 0);
    @(negedge tck); #1;
    trst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick(1, 0);
  endtask

  function automatic logic [3:0] ctl_now();
    return {c_el, c_il, c_em, c_im};
  endfunction

  initial begin
    #(TCK_PERIOD * 100000);
    n_err++;
    $display("FAIL R1 watchdog act=%0d exp=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [2:0] ic;
    logic [3:0] dc;
    do_reset();
    tick(0, 0);

    // R2: capture pattern observed on tdo, R8 control code loaded
    ir_scan(3'b001, ic);
    check(ic === 3'b001, "R2", "captured instruction bits", int'(ic), 1);

    // R7: core-logic test setting, first bit lands in bit 0
    dr_scan4(4'b0101, dc);
    check(ctl_now() === 4'b0101, "R7", "core test setting", int'(ctl_now()), 5);
    check(c_im === 1'b1 && c_em === 1'b0, "R7", "int/ext mode", int'({c_em, c_im}), 1);
    for (int i = 0; i < 20; i++) tick(0, i[0]);
    check(ctl_now() === 4'b0101, "R7", "kept through idle", int'(ctl_now()), 5);

    // R7: Capture-DR returns held value
    dr_scan4(4'b0000, dc);
    check(dc === 4'b0101, "R7", "captured held value", int'(dc), 5);
    check(ctl_now() === 4'b0000, "R4", "cleared by update", int'(ctl_now()), 0);

    // R6: pause part-way and resume; load 4'b1010
    tick(1, 0); tick(0, 0); tick(0, 0);
    tick(0, 0); tick(1, 1);
    tick(0, 1);
    for (int i = 0; i < 6; i++) tick(0, 1);
    check(ctl_now() === 4'b0000, "R6", "no change while paused", int'(ctl_now()), 0);
    tick(1, 1); tick(0, 1);
    tick(0, 0); tick(1, 1);
    tick(1, 0); tick(0, 0);
    check(ctl_now() === 4'b1010, "R6", "resumed scan result", int'(ctl_now()), 10);

    // R8: bypass code
    ir_scan(3'b111, ic);
    check(ic === 3'b001, "R5", "IR branch on tdo", int'(ic), 1);
    dr_scan4(4'b1011, dc);
    check(dc === 4'b0110, "R8", "bypass delay 111", int'(dc), 6);
    check(ctl_now() === 4'b1010, "R4", "controls untouched by bypass", int'(ctl_now()), 10);

    // R8: unused code and external test code fall to bypass
    ir_scan(3'b101, ic);
    dr_scan4(4'b1001, dc);
    check(dc === 4'b0010, "R8", "bypass delay 101", int'(dc), 2);
    ir_scan(3'b000, ic);
    dr_scan4(4'b0111, dc);
    check(dc === 4'b1110, "R8", "bypass delay 000", int'(dc), 14);
    check(ctl_now() === 4'b1010, "R4", "controls untouched", int'(ctl_now()), 10);

    // R9: network instruction
    ir_scan(3'b010, ic);
    check(n_sel === 1'b1, "R9", "net_select raised", int'(n_sel), 1);
    dr_scan4(4'b0011, dc);
    check(dc === 4'b1001, "R9", "network return on tdo", int'(dc), 9);
    check(ctl_now() === 4'b1010, "R9", "controls untouched", int'(ctl_now()), 10);

    // R1 / R10: five high tms from Shift-DR
    ir_scan(3'b001, ic);
    dr_scan4(4'b1111, dc);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 5; i++) tick(1, 0);
    check(ctl_now() === 4'b0000, "R10", "controls cleared in reset state", int'(ctl_now()), 0);
    check(n_sel === 1'b0, "R1", "net_select after escape", int'(n_sel), 0);
    tick(0, 0);
    dr_scan4(4'b0001, dc);
    check(dc === 4'b0010, "R10", "instruction back to bypass", int'(dc), 2);

    // R1: asynchronous reset mid-scan
    ir_scan(3'b001, ic);
    dr_scan4(4'b0101, dc);
    tick(1, 0); tick(0, 0); tick(0, 1);
    do_reset();
    tick(0, 0);
    dr_scan4(4'b0001, dc);
    check(dc === 4'b0010, "R1", "bypass after trst_n", int'(dc), 2);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule